// File: doc/BRIEF.md
# Iterative Multiplier with High/Low Select and Fused Addend

This unit multiplies two 64-bit operands over a sequence of clock cycles. It forms the exact 128-bit product and can add a third 64-bit operand to it before one half is chosen. The caller picks several options:

- signed (two's complement) or unsigned operands;
- the upper or the lower 64 bits of the 128-bit result;
- whether the addend is applied;
- whether the second operand comes from a 16-bit immediate;
- a word mode, which multiplies only the low 32 bits of each operand.

A product-overflow flag is produced for the low-half multiplies when the caller enables it.

Operation follows a start/busy/done handshake. A start pulse while the unit is idle captures all operands and mode inputs. `busy` then stays high while a radix-2 shift-add loop runs, taking one step per multiplier bit. A one-cycle `done` pulse marks the cycle in which `result` and `ovf` become valid. Both stay valid until the next operation completes.

The controller has three states:

| State | Activity | Transition |
|---|---|---|
| IDLE | Waits for `start` | IDLE to LOOP when `start` is high |
| LOOP | Runs one shift-add step per cycle on operand magnitudes | LOOP to FINAL after the last of the 64 steps |
| FINAL | Restores the sign, applies the addend, selects the half and computes overflow; registers the outputs and raises `done` | FINAL to IDLE unconditionally |

Top module: `mhl_mul_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `ovf` and `result` are all 0.
- R2: A `start` sampled high in IDLE captures the inputs. `busy` is high from the following cycle until `done`. `done` is a single-cycle pulse that rises exactly 65 clock edges after the edge that sampled `start`, and `busy` is low while `done` is high. `result` and `ovf` keep their values after `done` until the next completion.
- R3: A `start` sampled while `busy` is high is ignored: neither the running operation nor its timing changes.
- R4: With `word_md=0` and `hi_sel=0`, `result` is bits 63:0 of the 128-bit product. Operands are read as two's complement when `sgn=1` and as unsigned when `sgn=0`.
- R5: With `word_md=0` and `hi_sel=1`, `result` is bits 127:64 of the 128-bit product, with the same operand interpretation as R4.
- R6: With `word_md=0` and `add_en=1`, `op_c` is added across all 128 bits before the half is selected. `op_c` is sign-extended when `sgn=1` and zero-extended when `sgn=0`.
- R7: With `use_imm=1`, the second operand is `imm` sign-extended from 16 to 64 bits regardless of `sgn`, and `op_b` is ignored.
- R8: With `word_md=1` and `hi_sel=1`, bits 31:0 of each operand are extended according to `sgn` and multiplied. Bits 63:32 of that 64-bit product go to `result[31:0]`, and `result[63:32]` is 0. Operand bits 63:32 and `add_en` have no effect.
- R9: With `word_md=1` and `hi_sel=0`, `result` is the full 64-bit product of the two 32-bit words (extended per `sgn`). Operand bits 63:32 and `add_en` have no effect.
- R10: `ovf` is 1 only when all of the following hold: `ovf_en=1`, `hi_sel=0`, and either (a) `word_md=0`, `add_en=0`, and the product lies outside the signed 64-bit range, or (b) `word_md=1` and the product lies outside the signed 32-bit range. In every other case `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_a | input | 64 | First operand (multiplicand) |
| op_b | input | 64 | Second operand (multiplier) |
| op_c | input | 64 | Addend |
| imm | input | 16 | Immediate used as the second operand when `use_imm=1` |
| use_imm | input | 1 | Select the sign-extended immediate as the second operand |
| sgn | input | 1 | 1 = signed operands and sign-extended addend, 0 = unsigned |
| hi_sel | input | 1 | 1 = upper half, 0 = lower half |
| add_en | input | 1 | Add `op_c` to the product (doubleword mode only) |
| word_md | input | 1 | 32-bit word mode |
| ovf_en | input | 1 | Enable overflow reporting |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Selected result |
| ovf | output | 1 | Product overflow indication |

## Verification
On every cycle the assertions check the following:

- the single-cycle shape of `done` and that it never coincides with `busy`;
- that the loop counter advances by one each step;
- that mode state is held while a start arrives during a run;
- that the upper word of a word-high result is zero;
- that `ovf` stays low whenever it is not enabled or the upper half was selected.

Only the bench's directed scenarios can show that the arithmetic itself is correct. These cover:

- the signed and unsigned halves;
- the addend's sign versus zero extension;
- the immediate path;
- the word modes with junk in the upper operand bits;
- overflow at the exact edges of the signed range;
- the exact completion latency.

// File: rtl/mhl_pkg.sv
package mhl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOP  = 2'd1,
        ST_FINAL = 2'd2
    } mstate_t;

    typedef struct packed {
        logic sgn;
        logic hi;
        logic add;
        logic word;
        logic oe;
    } mmode_t;

endpackage

// File: rtl/mhl_opnd_prep.sv
module mhl_opnd_prep #(
    parameter int XLEN = 64,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [IMMW-1:0] imm,
    input  logic            use_imm,
    input  logic            sgn,
    input  logic            word_md,
    output logic [XLEN-1:0] a_mag,
    output logic [XLEN-1:0] b_mag,
    output logic            prod_neg
);
    localparam int WLEN = XLEN / 2;

    logic [XLEN-1:0] src [2];
    logic [XLEN-1:0] ext [2];
    logic [XLEN-1:0] mag [2];
    logic            neg [2];

    always_comb begin
        src[0] = op_a;
        src[1] = use_imm ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : op_b;
    end

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        always_comb begin
            if (word_md) begin
                ext[g] = sgn ? {{WLEN{src[g][WLEN-1]}}, src[g][WLEN-1:0]}
                             : {{WLEN{1'b0}}, src[g][WLEN-1:0]};
            end else begin
                ext[g] = src[g];
            end
            neg[g] = sgn & ext[g][XLEN-1];
            mag[g] = neg[g] ? -ext[g] : ext[g];
        end
    end

    assign a_mag    = mag[0];
    assign b_mag    = mag[1];
    assign prod_neg = neg[0] ^ neg[1];

endmodule

// File: rtl/mhl_shift_add.sv
module mhl_shift_add #(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [XLEN-1:0]   mcand,
    input  logic [XLEN-1:0]   mplier,
    output logic [2*XLEN-1:0] acc
);
    localparam int PLEN = 2 * XLEN;

    logic [PLEN-1:0] mc_q;
    logic [XLEN-1:0] mp_q;
    logic [PLEN-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q  <= '0;
            mp_q  <= '0;
            acc_q <= '0;
        end else if (load) begin
            mc_q  <= {{XLEN{1'b0}}, mcand};
            mp_q  <= mplier;
            acc_q <= '0;
        end else if (step) begin
            if (mp_q[0]) begin
                acc_q <= acc_q + mc_q;
            end
            mc_q <= mc_q << 1;
            mp_q <= mp_q >> 1;
        end
    end

    assign acc = acc_q;

    // R2: a load always starts from an empty accumulator
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q == '0));

endmodule

// File: rtl/mhl_result_fmt.sv
module mhl_result_fmt #(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0]   prod_mag,
    input  logic                neg,
    input  mhl_pkg::mmode_t     mode,
    input  logic [XLEN-1:0]     addend,
    output logic [XLEN-1:0]     res,
    output logic                ovf
);
    localparam int WLEN = XLEN / 2;
    localparam int PLEN = 2 * XLEN;

    logic [PLEN-1:0] prod;
    logic [PLEN-1:0] add_ext;
    logic [PLEN-1:0] sum;
    logic            fit_d;
    logic            fit_w;

    always_comb begin
        prod    = neg ? -prod_mag : prod_mag;
        add_ext = mode.sgn ? {{XLEN{addend[XLEN-1]}}, addend}
                           : {{XLEN{1'b0}}, addend};
        sum     = prod + ((mode.add && !mode.word) ? add_ext : '0);

        fit_d = (&prod[PLEN-1:XLEN-1]) | ~(|prod[PLEN-1:XLEN-1]);
        fit_w = (&prod[PLEN-1:WLEN-1]) | ~(|prod[PLEN-1:WLEN-1]);

        if (mode.word) begin
            res = mode.hi ? {{WLEN{1'b0}}, prod[XLEN-1:WLEN]} : prod[XLEN-1:0];
            ovf = mode.oe & ~mode.hi & ~fit_w;
        end else begin
            res = mode.hi ? sum[PLEN-1:XLEN] : sum[XLEN-1:0];
            ovf = mode.oe & ~mode.hi & ~mode.add & ~fit_d;
        end
    end

endmodule

// File: rtl/mhl_mul_unit.sv
module mhl_mul_unit #(
    parameter int XLEN = 64,
    parameter int IMMW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] op_c,
    input  logic [IMMW-1:0] imm,
    input  logic            use_imm,
    input  logic            sgn,
    input  logic            hi_sel,
    input  logic            add_en,
    input  logic            word_md,
    input  logic            ovf_en,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            ovf
);
    import mhl_pkg::*;

    localparam int WLEN = XLEN / 2;
    localparam int PLEN = 2 * XLEN;
    localparam int CW   = $clog2(XLEN);
    localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);

    mstate_t         st_q, st_d;
    logic [CW-1:0]   cnt_q;
    mmode_t          mode_q;
    logic            neg_q;
    logic [XLEN-1:0] addend_q;
    logic            accept;

    logic [XLEN-1:0] a_mag, b_mag;
    logic            neg_d;
    logic [PLEN-1:0] prod_mag;
    logic [XLEN-1:0] fmt_res;
    logic            fmt_ovf;

    assign accept = (st_q == ST_IDLE) && start;

    mhl_opnd_prep #(.XLEN(XLEN), .IMMW(IMMW)) u_prep (
        .op_a     (op_a),
        .op_b     (op_b),
        .imm      (imm),
        .use_imm  (use_imm),
        .sgn      (sgn),
        .word_md  (word_md),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .prod_neg (neg_d)
    );

    mhl_shift_add #(.XLEN(XLEN)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (st_q == ST_LOOP),
        .mcand  (a_mag),
        .mplier (b_mag),
        .acc    (prod_mag)
    );

    mhl_result_fmt #(.XLEN(XLEN)) u_fmt (
        .prod_mag (prod_mag),
        .neg      (neg_q),
        .mode     (mode_q),
        .addend   (addend_q),
        .res      (fmt_res),
        .ovf      (fmt_ovf)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_LOOP;
            ST_LOOP:  if (cnt_q == LAST_STEP) st_d = ST_FINAL;
            ST_FINAL: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // counter, captured modes and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            mode_q   <= '0;
            neg_q    <= 1'b0;
            addend_q <= '0;
            result   <= '0;
            ovf      <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) begin
                        mode_q   <= '{sgn: sgn, hi: hi_sel, add: add_en,
                                      word: word_md, oe: ovf_en};
                        neg_q    <= neg_d;
                        addend_q <= op_c;
                    end
                end
                ST_LOOP: begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_FINAL: begin
                    result <= fmt_res;
                    ovf    <= fmt_ovf;
                    done   <= 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign busy = (st_q != ST_IDLE);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOP && $past(st_q) == ST_LOOP) |-> (cnt_q == CW'($past(cnt_q) + 1'b1)));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(mode_q) && $stable(addend_q) && $stable(neg_q)));

    // R8
    word_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q.word && mode_q.hi) |-> (result[XLEN-1:WLEN] == '0));

    // R10
    ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (!mode_q.oe || mode_q.hi)) |-> !ovf);

endmodule

// File: tb/mhl_mul_unit_test.sv
`timescale 1ns/1ps
module mhl_mul_unit_test;
    localparam int XLEN = 64;
    localparam int LAT  = XLEN + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [XLEN-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic [15:0]     imm = '0;
    logic            use_imm = 0, sgn = 0, hi_sel = 0, add_en = 0, word_md = 0, ovf_en = 0;
    logic            busy, done, ovf;
    logic [XLEN-1:0] result;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    mhl_mul_unit #(.XLEN(XLEN), .IMMW(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .imm(imm),
        .use_imm(use_imm), .sgn(sgn), .hi_sel(hi_sel), .add_en(add_en),
        .word_md(word_md), .ovf_en(ovf_en),
        .busy(busy), .done(done), .result(result), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent reference: exact 128-bit arithmetic, returns {ovf, result}
    function automatic logic [64:0] model(input logic [63:0] a, b, c, input logic [15:0] im,
                                          input bit ui, sg, hi, ad, wd, oe);
        logic [127:0]        ea, eb, p, s, ce;
        logic signed [127:0] sp, lo_lim, hi_lim;
        logic [63:0]         bb, r;
        bit                  o;
        bb = ui ? {{48{im[15]}}, im} : b;
        if (wd) begin
            ea = sg ? {{96{a[31]}}, a[31:0]} : {96'd0, a[31:0]};
            eb = sg ? {{96{bb[31]}}, bb[31:0]} : {96'd0, bb[31:0]};
        end else begin
            ea = sg ? {{64{a[63]}}, a} : {64'd0, a};
            eb = sg ? {{64{bb[63]}}, bb} : {64'd0, bb};
        end
        p  = ea * eb;
        sp = p;
        if (wd) begin
            hi_lim = (128'sd1 <<< 31) - 128'sd1;
            lo_lim = -(128'sd1 <<< 31);
            r = hi ? {32'd0, p[63:32]} : p[63:0];
            o = oe && !hi && ((sp > hi_lim) || (sp < lo_lim));
        end else begin
            hi_lim = (128'sd1 <<< 63) - 128'sd1;
            lo_lim = -(128'sd1 <<< 63);
            ce = sg ? {{64{c[63]}}, c} : {64'd0, c};
            s  = p + (ad ? ce : 128'd0);
            r  = hi ? s[127:64] : s[63:0];
            o  = oe && !hi && !ad && ((sp > hi_lim) || (sp < lo_lim));
        end
        return {o, r};
    endfunction

    task automatic drive(input logic [63:0] a, b, c, input logic [15:0] im,
                         input bit ui, sg, hi, ad, wd, oe);
        op_a = a; op_b = b; op_c = c; imm = im;
        use_imm = ui; sgn = sg; hi_sel = hi; add_en = ad; word_md = wd; ovf_en = oe;
    endtask

    // waits for done after the start edge; n counts edges since that edge
    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 300) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic run_op(input string tag, input logic [63:0] a, b, c, input logic [15:0] im,
                          input bit ui, sg, hi, ad, wd, oe);
        logic [64:0] exp;
        int          n;
        exp = model(a, b, c, im, ui, sg, hi, ad, wd, oe);
        @(negedge clk);
        drive(a, b, c, im, ui, sg, hi, ad, wd, oe);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        drive('1, '1, '1, '1, ~ui, ~sg, ~hi, ~ad, ~wd, ~oe);
        chk(busy == 1'b1, {"R2 busy after start ", tag}, 64'(busy), 64'd1);
        wait_done(n);
        chk(n == LAT, {"R2 latency ", tag}, 64'(n), 64'(LAT));
        chk(result == exp[63:0], {"result ", tag}, result, exp[63:0]);
        chk(ovf == exp[64], {"R10 ovf ", tag}, 64'(ovf), 64'(exp[64]));
        @(posedge clk); #1;
        chk(done == 1'b0, {"R2 done pulse width ", tag}, 64'(done), 64'd0);
        chk(result == exp[63:0], {"R2 result hold ", tag}, result, exp[63:0]);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk({busy, done, ovf} == 3'b000, "R1 control outputs in reset", 64'({busy, done, ovf}), 64'd0);
        chk(result == '0, "R1 result in reset", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk({busy, done, ovf} == 3'b000, "R1 control outputs after reset", 64'({busy, done, ovf}), 64'd0);
    endtask

    task automatic t_dword_low;
        run_op("R4 unsigned small", 64'd3, 64'd5, 0, 0, 0, 0, 0, 0, 0, 0);
        run_op("R4 signed mixed", -64'sd7, 64'd9, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R4 unsigned wrap", '1, 64'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_dword_high;
        run_op("R5 signed minus one squared", '1, '1, 0, 0, 0, 1, 1, 0, 0, 0);
        run_op("R5 unsigned all ones squared", '1, '1, 0, 0, 0, 0, 1, 0, 0, 0);
        run_op("R5 signed min squared", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
               0, 0, 0, 1, 1, 0, 0, 0);
    endtask

    task automatic t_addend;
        run_op("R6 signed high negative addend", '1, 64'd1, '1, 0, 0, 1, 1, 1, 0, 0);
        run_op("R6 unsigned high zero-extended addend", 64'h1_0000_0000, 64'h1_0000_0000,
               '1, 0, 0, 0, 1, 1, 0, 0);
        run_op("R6 signed low with carry", 64'h7fff_ffff_ffff_ffff, 64'd2, 64'd5,
               0, 0, 1, 0, 1, 0, 0);
    endtask

    task automatic t_imm;
        run_op("R7 signed negative immediate", 64'd10, 64'd12345, 0, 16'hFFFE, 1, 1, 0, 0, 0, 0);
        run_op("R7 immediate extended when unsigned", 64'd10, 64'd7, 0, 16'h8000, 1, 0, 1, 0, 0, 0);
    endtask

    task automatic t_word;
        run_op("R8 signed word high junk upper", 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0002,
               0, 0, 0, 1, 1, 0, 1, 0);
        run_op("R8 unsigned word high", 64'hDEAD_BEEF_FFFF_FFFF, 64'h0000_0001_0000_0002,
               0, 0, 0, 0, 1, 0, 1, 0);
        run_op("R9 signed word low addend ignored", 64'hAAAA_AAAA_FFFF_FFFD, 64'd4,
               64'd5, 0, 0, 1, 0, 1, 1, 0);
        run_op("R9 unsigned word low", 64'h5555_5555_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF,
               0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_ovf;
        run_op("R10 dword signed overflow", 64'h4000_0000_0000_0000, 64'd4, 0, 0, 0, 1, 0, 0, 0, 1);
        run_op("R10 dword disabled", 64'h4000_0000_0000_0000, 64'd4, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R10 dword high no flag", 64'h4000_0000_0000_0000, 64'd4, 0, 0, 0, 1, 1, 0, 0, 1);
        run_op("R10 dword addend no flag", 64'h4000_0000_0000_0000, 64'd4, 64'd1, 0, 0, 1, 0, 1, 0, 1);
        run_op("R10 dword exact signed minimum", 64'hC000_0000_0000_0000, 64'd2, 0, 0, 0, 1, 0, 0, 0, 1);
        run_op("R10 dword unsigned above signed max", 64'h8000_0000_0000_0000, 64'd1, 0, 0, 0, 0, 0, 0, 0, 1);
        run_op("R10 word overflow", 64'h0001_0000, 64'h8000, 0, 0, 0, 1, 0, 0, 1, 1);
        run_op("R10 word exact minimum", 64'h0001_0000, 64'hFFFF_FFFF_FFFF_8000, 0, 0, 0, 1, 0, 0, 1, 1);
    endtask

    task automatic t_busy_start;
        logic [64:0] exp;
        int          n;
        exp = model(64'd1000, 64'd3000, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        drive(64'd1000, 64'd3000, 0, 0, 0, 0, 0, 0, 0, 0);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (9) @(posedge clk);
        #1;
        drive(64'd7, 64'd7, 64'd9, 0, 0, 1, 1, 1, 0, 1);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 10;
        while (!done && n < 300) begin
            @(posedge clk); #1;
            n++;
        end
        chk(n == LAT, "R3 latency unchanged by start while busy", 64'(n), 64'(LAT));
        chk(result == exp[63:0], "R3 result from first operands", result, exp[63:0]);
        @(posedge clk); #1;
        chk(busy == 1'b0, "R3 no second run started", 64'(busy), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_dword_low();
        t_dword_high();
        t_addend();
        t_imm();
        t_word();
        t_ovf();
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule